// File: doc/BRIEF.md
# Over-Current Pulse-Skip Sequencer

This block handles over-current events for a synchronous buck regulator by counting switching cycles. A one-clock strobe marks the start of each switching cycle. At that strobe the block samples a current-limit detect flag. When the flag is high while the regulator runs normally, the high-side switch is held off for that cycle and for the next eight. This is the skip phase. During the skip phase the flag is not looked at.

After the skip phase the high-side switch runs again, and the block watches cycles 9 through 16. If the flag appears at the start of any of those cycles, the block concludes that the overload persists. It then enters a latched fault: the high-side stays inhibited, a fault flag is raised and a power-good-low request is sent. If the window passes without an event, the block goes back to normal operation by itself. The latched fault ends only when enable is dropped or the supply is cycled, which this block sees as reset.

The block is a four-state machine:
- `NORMAL` is the running state.
- `SKIP` covers the detection cycle and cycles 1..8.
- `WATCH` covers cycles 9..16.
- `TRIPPED` is the latched fault.

Its transitions are:
- detect: `NORMAL` to `SKIP`.
- skip-done: `SKIP` to `WATCH`.
- early-recur: `SKIP` to `TRIPPED`, at the strobe that starts cycle 9.
- recur: `WATCH` to `TRIPPED`.
- recover: `WATCH` to `NORMAL`, at the strobe that starts cycle 17 with no event.
- re-detect: `WATCH` to `SKIP`, at the strobe that starts cycle 17 with an event.
- disable: any state to `NORMAL` while enable is low.

A shared strobe counter numbers the cycles. The detection cycle is cycle 0.

Top module: `ocp_skip_seq`

## Requirements
- R1: With `en` high and the sequencer in normal operation, a strobe with `ilim_hit` high asserts `hs_inhibit` at the next clock edge. That cycle is the detection cycle (cycle 0).
- R2: `hs_inhibit` stays high through the eight cycles that follow the detection cycle (cycles 1..8). `ilim_hit` has no effect during those cycles.
- R3: A strobe with `ilim_hit` high that starts any of cycles 9..16 sets the latched fault at the next clock edge. In the latched fault, `oc_latched`, `pg_low_req` and `hs_inhibit` are all 1.
- R4: If no strobe starting cycles 9..16 carries `ilim_hit`, `hs_inhibit` is 0 during those cycles and the sequencer returns to normal at the strobe that starts cycle 17. If that strobe carries `ilim_hit`, a fresh sequence begins with a new cycle 0. The cycle counter never exceeds 16.
- R5: While `en` stays high, the latched fault holds whatever the strobes and `ilim_hit` do.
- R6: `en` low returns the block to normal operation at the next clock edge, with all outputs 0, and clears a latched fault. While `en` is low, strobes and `ilim_hit` are ignored.
- R7: After reset, `hs_inhibit`, `oc_latched` and `pg_low_req` are 0.
- R8: `ilim_hit` is sampled only with `cyc_strobe`. A high flag without a strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset (supply cycling) |
| en | input | 1 | Regulator enable; low clears a latched fault |
| cyc_strobe | input | 1 | One-clock pulse at the start of each switching cycle |
| ilim_hit | input | 1 | Current-limit detect flag, sampled with the strobe |
| hs_inhibit | output | 1 | Holds the high-side switch off |
| oc_latched | output | 1 | Over-current protection latch is set |
| pg_low_req | output | 1 | Request to pull power-good low |

## Verification
Complete episodes are run in which the flag recurs at cycle 9, at cycle 13, at cycle 16, or not at all. Each episode also raises the flag on alternate skip cycles:
- The cycle-9 and cycle-16 recurrences tell an off-by-one at the window edges apart from a correct window.
- The alternating skip-phase hits show whether the skip phase really ignores the flag.

An event placed at the cycle-17 strobe separates recovery followed by re-detection from a window that is one cycle too long. Strobes and flags applied while the block is latched, while it is disabled, and flags applied without a strobe check that the fault holds and that the inputs are ignored.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_SKIP    = 2'd1,
        ST_WATCH   = 2'd2,
        ST_TRIPPED = 2'd3
    } ocp_state_e;

endpackage

// File: rtl/ocp_cycle_counter.sv
module ocp_cycle_counter #(
    parameter int CNT_W   = 5,
    parameter int CNT_MAX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

    // R4
    cnt_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);

endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
    import ocp_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cyc_strobe,
    input  logic             ilim_hit,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output ocp_state_e       state
);

    localparam logic [CNT_W-1:0] SKIP_END = CNT_W'(SKIP_CYCLES);
    localparam logic [CNT_W-1:0] WIN_END  = CNT_W'(SKIP_CYCLES + WATCH_CYCLES);

    ocp_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!en) begin
            nxt     = ST_NORMAL;
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                ST_NORMAL: begin
                    if (cyc_strobe && ilim_hit) begin
                        nxt     = ST_SKIP;
                        cnt_clr = 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (cyc_strobe) begin
                        if (count == SKIP_END) begin
                            if (ilim_hit) begin
                                nxt = ST_TRIPPED;
                            end else begin
                                nxt     = ST_WATCH;
                                cnt_inc = 1'b1;
                            end
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_WATCH: begin
                    if (cyc_strobe) begin
                        if (count == WIN_END) begin
                            cnt_clr = 1'b1;
                            nxt     = ilim_hit ? ST_SKIP : ST_NORMAL;
                        end else if (ilim_hit) begin
                            nxt = ST_TRIPPED;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_TRIPPED: begin
                    nxt = ST_TRIPPED;
                end
                default: begin
                    nxt = ST_NORMAL;
                end
            endcase
        end
    end

    // R1
    detect_enter_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cyc_strobe && ilim_hit && state == ST_NORMAL) |=> (state == ST_SKIP));

    // R2
    skip_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (count <= SKIP_END));

    // R4
    watch_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH) |-> ((count > SKIP_END) && (count <= WIN_END)));

    // R3
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_TRIPPED) |-> $past(cyc_strobe && ilim_hit && en));

    // R5
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIPPED && en) |=> (state == ST_TRIPPED));

    // R6
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_NORMAL));

    // R8
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && en && !cyc_strobe) |=> (state == ST_NORMAL));

endmodule

// File: rtl/ocp_out_decode.sv
module ocp_out_decode
    import ocp_pkg::*;
(
    input  ocp_state_e state,
    output logic       hs_inhibit,
    output logic       oc_latched,
    output logic       pg_low_req
);

    always_comb begin
        hs_inhibit = 1'b0;
        oc_latched = 1'b0;
        pg_low_req = 1'b0;
        unique case (state)
            ST_NORMAL:  ;
            ST_SKIP:    hs_inhibit = 1'b1;
            ST_WATCH:   ;
            ST_TRIPPED: begin
                hs_inhibit = 1'b1;
                oc_latched = 1'b1;
                pg_low_req = 1'b1;
            end
            default:    ;
        endcase
    end

endmodule

// File: rtl/ocp_skip_seq.sv
module ocp_skip_seq
    import ocp_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_strobe,
    input  logic ilim_hit,
    output logic hs_inhibit,
    output logic oc_latched,
    output logic pg_low_req
);

    localparam int CNT_MAX = SKIP_CYCLES + WATCH_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] count;
    logic             cnt_clr;
    logic             cnt_inc;
    ocp_state_e       state;

    ocp_cycle_counter #(
        .CNT_W   (CNT_W),
        .CNT_MAX (CNT_MAX)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    ocp_seq_fsm #(
        .SKIP_CYCLES  (SKIP_CYCLES),
        .WATCH_CYCLES (WATCH_CYCLES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cyc_strobe (cyc_strobe),
        .ilim_hit   (ilim_hit),
        .count      (count),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .state      (state)
    );

    ocp_out_decode u_decode (
        .state      (state),
        .hs_inhibit (hs_inhibit),
        .oc_latched (oc_latched),
        .pg_low_req (pg_low_req)
    );

    // R6
    latch_clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_latched && !en) |=> !oc_latched);

endmodule

// File: tb/ocp_skip_seq_bench.sv
module ocp_skip_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic cyc_strobe = 1'b0;
    logic ilim_hit = 1'b0;
    logic hs_inhibit;
    logic oc_latched;
    logic pg_low_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit    inh;
        bit    lat;
        bit    pg;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event smp;

    always #5 clk = ~clk;

    ocp_skip_seq u_ocp_skip_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cyc_strobe (cyc_strobe),
        .ilim_hit   (ilim_hit),
        .hs_inhibit (hs_inhibit),
        .oc_latched (oc_latched),
        .pg_low_req (pg_low_req)
    );

    // Monitor: pops the expected item and compares it with the outputs.
    initial begin
        forever begin
            @(smp);
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty: actual=sample expected=item");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (hs_inhibit !== e.inh || oc_latched !== e.lat || pg_low_req !== e.pg) begin
                    failures++;
                    $display("FAIL %s: actual inh=%b lat=%b pg=%b expected inh=%b lat=%b pg=%b",
                             e.tag, hs_inhibit, oc_latched, pg_low_req, e.inh, e.lat, e.pg);
                end
            end
        end
    end

    // Driver: pushes the expected result, applies one clock of stimulus, triggers the monitor.
    task automatic step(input bit stb, input bit hit, input bit ei, input bit el,
                        input bit ep, input string tag);
        exp_t e;
        e.inh = ei;
        e.lat = el;
        e.pg  = ep;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        cyc_strobe = stb;
        ilim_hit   = hit;
        @(negedge clk);
        cyc_strobe = 1'b0;
        ilim_hit   = 1'b0;
        -> smp;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        en = v;
    endtask

    // One over-current episode. trip_at in 9..16 places a recurrence there; 0 means none.
    task automatic episode(input int trip_at);
        step(1, 1, 1, 0, 0, "R1 detection cycle inhibits high side");
        for (int k = 1; k <= 8; k++) begin
            step(1, (k % 2 == 1), 1, 0, 0, "R2 skip cycle inhibited, flag ignored");
        end
        for (int k = 9; k <= 16; k++) begin
            if (k == trip_at) begin
                step(1, 1, 1, 1, 1, "R3 recurrence in window latches fault");
                return;
            end
            step(1, 0, 0, 0, 0, "R4 window cycle not inhibited");
        end
        step(1, 0, 0, 0, 0, "R4 recovered after quiet window");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R7 reset state");
        step(0, 1, 0, 0, 0, "R8 flag without strobe ignored");
        step(1, 0, 0, 0, 0, "R8 strobe without flag keeps normal");

        episode(0);
        episode(9);
        step(1, 0, 1, 1, 1, "R5 latch holds on quiet strobe");
        step(1, 1, 1, 1, 1, "R5 latch holds on flagged strobe");
        step(0, 0, 1, 1, 1, "R5 latch holds without strobe");

        set_en(1'b0);
        step(1, 1, 0, 0, 0, "R6 disable clears latch and ignores flag");
        set_en(1'b1);
        step(1, 0, 0, 0, 0, "R6 normal after re-enable");

        episode(16);
        set_en(1'b0);
        step(0, 0, 0, 0, 0, "R6 disable clears latch");
        set_en(1'b1);

        episode(13);
        set_en(1'b0);
        step(0, 0, 0, 0, 0, "R6 disable clears latch again");
        set_en(1'b1);

        // Disable in the middle of the skip phase.
        step(1, 1, 1, 0, 0, "R1 detection before mid-skip disable");
        step(1, 0, 1, 0, 0, "R2 skip cycle before disable");
        set_en(1'b0);
        step(0, 0, 0, 0, 0, "R6 disable ends skip phase");
        set_en(1'b1);

        // An event at the strobe that starts cycle 17 opens a fresh sequence.
        step(1, 1, 1, 0, 0, "R1 detection for cycle-17 case");
        for (int k = 1; k <= 8; k++) begin
            step(1, 0, 1, 0, 0, "R2 skip cycle before cycle-17 case");
        end
        for (int k = 9; k <= 16; k++) begin
            step(1, 0, 0, 0, 0, "R4 quiet window before cycle 17");
        end
        step(1, 1, 1, 0, 0, "R4 hit at cycle 17 starts fresh sequence");
        for (int k = 1; k <= 8; k++) begin
            step(1, 0, 1, 0, 0, "R4 fresh sequence skips cycles 1..8");
        end
        step(1, 0, 0, 0, 0, "R4 fresh sequence releases at cycle 9");

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule